// File: doc/BRIEF.md
# Comparator-Gated Event Timer

This block is a 16-bit event counter for measuring how long an analog condition lasts, or how far apart two such conditions are. The counter advances on a timer clock. That clock is either the system clock or the system clock divided by four, and it is then slowed further by a selectable prescaler of 1, 2, 4 or 8. When gating is enabled, counting is qualified by a gate level. The gate level comes either from an external gate pin or from the output of the second analog comparator.

All three asynchronous inputs (gate pin and both comparator outputs) pass through two-flop synchronizers. The second comparator's output can additionally be captured on the falling edge of the post-prescaler timer clock. The counter moves on the rising edge, so a comparator change never lands inside an increment. Both edges are one-cycle strobes in the system-clock domain.

A small control/status byte holds the clock select, the gate-source select, the capture enable and two stored-only hysteresis enables. It also shows both synchronized comparator levels side by side, taken in the same cycle.

Top module: `cmp_gated_timer`

## Requirements
- R1: After reset, the count is 0 and the overflow flag is low. The control byte reads 0x02 (gate source = pin, everything else 0) while both comparator inputs are low.
- R2: Control byte layout: bit 7 is the comparator-1 level, bit 6 the comparator-2 level, bit 5 reads 0, bit 4 is the clock select, bit 3 the hysteresis-1 enable, bit 2 the hysteresis-2 enable, bit 1 the gate source and bit 0 the capture enable. A write loads bits 4..0 at the next edge. Bits 7..5 ignore writes.
- R3: A comparator input change shows in bits 7/6 two clock edges later and not after one edge. Both bits come from the same synchronizer stage.
- R4: The timer period is P = (clock select ? 1 : 4) × 2^prescaler system cycles. With the timer on for M edges starting from phase 0 and the gate not blocking, the count grows by floor(M/P). It changes by at most 1 per edge.
- R5: With the timer off, the count holds and the phase returns to 0.
- R6: With gating disabled, the gate level has no effect on counting.
- R7: With gating enabled and gate source = 1, the synchronized gate pin qualifies counting (active high). A low gate holds the count.
- R8: With gate source = 0 and capture disabled, the synchronized comparator-2 level is used directly at each rising strobe.
- R9: With capture enabled, the comparator-2 level is latched on the falling strobe, one cycle before the rising strobe (the same cycle when P = 1). The counter uses only the latched value.
- R10: The count wraps from 0xFFFF to 0x0000. The overflow flag is high for exactly the one cycle after that increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gate_pin_i | input | 1 | External gate pin, asynchronous |
| cmp1_i | input | 1 | Comparator-1 output, asynchronous |
| cmp2_i | input | 1 | Comparator-2 output, asynchronous |
| tmr_on_i | input | 1 | Timer run enable |
| gate_en_i | input | 1 | Gating enable |
| presc_i | input | 2 | Prescaler select, divide by 2^presc_i |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data |
| ctl_rdata_o | output | 8 | Control/status byte |
| count_o | output | 16 | Counter value |
| ovf_o | output | 1 | One-cycle wrap pulse |

## Verification
- **Control byte:** a write to it is visible one edge later. A comparator input reaches the mirror bits two edges later, and the bench samples at the falling clock after both one and two edges to pin that boundary.
- **Counting:** each run starts from phase 0 and lasts an exact number of edges. The expected increment is therefore floor(M/P), and for a gated run it is the count of rising strobes whose gate was high.
- **Capture vs. pass-through:** the capture check places a comparator-2 drop so that it reaches the synchronizer output after the falling strobe but before the rising strobe. With capture on, that period still counts; with capture off, it does not.
- **Overflow:** the flag is sampled in the cycle right after the wrap edge and again one cycle later.

// File: rtl/cgt_pkg.sv
package cgt_pkg;
  typedef struct packed {
    logic clk_sel;   // 1: system clock, 0: system clock / 4
    logic hys1;
    logic hys2;
    logic gate_sel;  // 1: gate pin, 0: comparator 2
    logic sync_en;
  } ctl_t;

  localparam ctl_t CTL_RST = '{clk_sel: 1'b0, hys1: 1'b0, hys2: 1'b0,
                               gate_sel: 1'b1, sync_en: 1'b0};
endpackage

// File: rtl/cgt_sync.sv
module cgt_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cgt_tick.sv
module cgt_tick #(
  parameter int PRESC_W  = 2,
  parameter int DIV_LOG2 = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               on_i,
  input  logic               clk_sel_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               rise_o,
  output logic               fall_o
);
  localparam int PH_W = DIV_LOG2 + (1 << PRESC_W) - 1;
  localparam logic [PH_W:0] ONE  = (PH_W+1)'(1);
  localparam logic [PH_W:0] TWO  = (PH_W+1)'(2);
  localparam logic [PH_W:0] BDIV = (PH_W+1)'(1 << DIV_LOG2);

  logic [PH_W-1:0] ph_q;
  logic [PH_W:0]   per, ph_x;

  always_comb begin
    per    = (clk_sel_i ? ONE : BDIV) << presc_i;
    ph_x   = {1'b0, ph_q};
    rise_o = on_i && (ph_x >= per - ONE);
    // falling strobe sits one cycle ahead of the rising one
    fall_o = on_i && ((per == ONE) || (ph_x == per - TWO));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ph_q <= '0;
    else if (!on_i || rise_o)  ph_q <= '0;
    else                       ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/cgt_gate.sv
module cgt_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic c2_s_i,
  input  logic gate_sel_i,
  input  logic sync_en_i,
  input  logic fall_i,
  output logic c2_lat_o,
  output logic gate_o
);
  logic c2_lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     c2_lat_q <= 1'b0;
    else if (fall_i) c2_lat_q <= c2_s_i;
  end

  assign c2_lat_o = c2_lat_q;
  assign gate_o   = gate_sel_i ? pin_s_i : (sync_en_i ? c2_lat_q : c2_s_i);
endmodule

// File: rtl/cgt_count.sv
module cgt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= inc_i && (&cnt_q);
      if (inc_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/cmp_gated_timer.sv
module cmp_gated_timer #(
  parameter int CNT_W    = 16,
  parameter int PRESC_W  = 2,
  parameter int DIV_LOG2 = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gate_pin_i,
  input  logic               cmp1_i,
  input  logic               cmp2_i,
  input  logic               tmr_on_i,
  input  logic               gate_en_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               ctl_we_i,
  input  logic [7:0]         ctl_wdata_i,
  output logic [7:0]         ctl_rdata_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               ovf_o
);
  import cgt_pkg::*;

  ctl_t       ctl_q;
  logic [2:0] sync_q;
  logic       pin_s, c1_s, c2_s;
  logic       rise_stb, fall_stb, gate_lvl, c2_lat, inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= CTL_RST;
    else if (ctl_we_i) ctl_q <= ctl_t'(ctl_wdata_i[4:0]);
  end

  cgt_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({gate_pin_i, cmp1_i, cmp2_i}),
    .q_o   (sync_q)
  );
  assign {pin_s, c1_s, c2_s} = sync_q;

  cgt_tick #(.PRESC_W(PRESC_W), .DIV_LOG2(DIV_LOG2)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .on_i     (tmr_on_i),
    .clk_sel_i(ctl_q.clk_sel),
    .presc_i  (presc_i),
    .rise_o   (rise_stb),
    .fall_o   (fall_stb)
  );

  cgt_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_s_i   (pin_s),
    .c2_s_i    (c2_s),
    .gate_sel_i(ctl_q.gate_sel),
    .sync_en_i (ctl_q.sync_en),
    .fall_i    (fall_stb),
    .c2_lat_o  (c2_lat),
    .gate_o    (gate_lvl)
  );

  assign inc = tmr_on_i && rise_stb && (!gate_en_i || gate_lvl);

  cgt_count #(.CNT_W(CNT_W)) u_count (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc),
    .cnt_o (count_o),
    .ovf_o (ovf_o)
  );

  assign ctl_rdata_o = {c1_s, c2_s, 1'b0, ctl_q};
endmodule

// File: rtl/cgt_chk.sv
module cgt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tmr_on_i,
  input logic             gate_en_i,
  input logic             ctl_we_i,
  input logic [7:0]       ctl_wdata_i,
  input logic [7:0]       ctl_rdata_o,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o,
  input logic             rise_stb,
  input logic             fall_stb,
  input logic             pin_s,
  input logic             c2_s,
  input logic             c2_lat
);
  AST_CTL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> ctl_rdata_o[4:0] == $past(ctl_wdata_i[4:0])); // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1)); // R4
  AST_ONLY_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_stb |=> $stable(count_o)); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_on_i |=> $stable(count_o)); // R5
  AST_PIN_GATE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_i && ctl_rdata_o[1] && !pin_s) |=> $stable(count_o)); // R7
  AST_LATCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_stb |=> $stable(c2_lat)); // R9
  AST_LATCH_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_stb |=> c2_lat == $past(c2_s)); // R9
  AST_OVF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o); // R10
  AST_OVF_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> count_o == '0); // R10
endmodule

bind cmp_gated_timer cgt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tmr_on_i   (tmr_on_i),
  .gate_en_i  (gate_en_i),
  .ctl_we_i   (ctl_we_i),
  .ctl_wdata_i(ctl_wdata_i),
  .ctl_rdata_o(ctl_rdata_o),
  .count_o    (count_o),
  .ovf_o      (ovf_o),
  .rise_stb   (rise_stb),
  .fall_stb   (fall_stb),
  .pin_s      (pin_s),
  .c2_s       (c2_s),
  .c2_lat     (c2_lat)
);

// File: tb/tb_cmp_gated_timer.sv
module tb_cmp_gated_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        gate_pin_i = 1'b0, cmp1_i = 1'b0, cmp2_i = 1'b0;
  logic        tmr_on_i = 1'b0, gate_en_i = 1'b0;
  logic [1:0]  presc_i = 2'd0;
  logic        ctl_we_i = 1'b0;
  logic [7:0]  ctl_wdata_i = 8'h00;
  logic [7:0]  ctl_rdata_o;
  logic [15:0] count_o;
  logic        ovf_o;

  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  cmp_gated_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .gate_pin_i(gate_pin_i), .cmp1_i(cmp1_i),
    .cmp2_i(cmp2_i), .tmr_on_i(tmr_on_i), .gate_en_i(gate_en_i),
    .presc_i(presc_i), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
    .ctl_rdata_o(ctl_rdata_o), .count_o(count_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_we_i = 1'b1; ctl_wdata_i = d;
    @(negedge clk);
    ctl_we_i = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // timer on for exactly m edges from phase 0, then one idle edge
  task automatic run(input int m, output int delta);
    logic [15:0] c0;
    c0 = count_o;
    tmr_on_i = 1'b1;
    repeat (m) @(negedge clk);
    tmr_on_i = 1'b0;
    @(negedge clk);
    delta = int'(16'(count_o - c0));
  endtask

  // capture scenario: P = 8, comparator 2 drops after the fifth edge
  task automatic drop_run(input bit sync, output int delta);
    logic [15:0] c0;
    int d;
    cmp2_i = 1'b1;
    wr({3'b000, 1'b0, 2'b00, 1'b0, sync});
    wait_n(3);
    run(8, d);           // primes the capture latch with 1
    c0 = count_o;
    tmr_on_i = 1'b1;
    wait_n(5);
    cmp2_i = 1'b0;
    wait_n(3);
    tmr_on_i = 1'b0;
    @(negedge clk);
    delta = int'(16'(count_o - c0));
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int d;
    wait_n(3);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(count_o == 16'h0, "R1 count", count_o, 0);
    chk(ovf_o == 1'b0, "R1 ovf", ovf_o, 0);
    chk(ctl_rdata_o == 8'h02, "R1 ctl", ctl_rdata_o, 8'h02);

    // R2 layout and write behaviour
    wr(8'hFF);
    chk(ctl_rdata_o == 8'h1F, "R2 write ones", ctl_rdata_o, 8'h1F);
    wr(8'h00);
    chk(ctl_rdata_o == 8'h00, "R2 write zeros", ctl_rdata_o, 8'h00);
    wr(8'hAC);
    chk(ctl_rdata_o == 8'h0C, "R2 hys stored", ctl_rdata_o, 8'h0C);

    // R3 mirror latency
    cmp1_i = 1'b1; cmp2_i = 1'b0;
    @(negedge clk);
    chk(ctl_rdata_o[7:6] == 2'b00, "R3 one edge", ctl_rdata_o[7:6], 0);
    @(negedge clk);
    chk(ctl_rdata_o[7:6] == 2'b10, "R3 two edges", ctl_rdata_o[7:6], 2);
    cmp1_i = 1'b0; cmp2_i = 1'b1;
    wait_n(2);
    chk(ctl_rdata_o[7:5] == 3'b010, "R3 swap", ctl_rdata_o[7:5], 2);
    cmp2_i = 1'b0;
    wait_n(2);

    // R4 period sweep, gating off
    gate_en_i = 1'b0;
    for (int cs = 0; cs < 2; cs++) begin
      for (int ps = 0; ps < 4; ps++) begin
        int p;
        p = (cs != 0 ? 1 : 4) << ps;
        wr({3'b000, cs[0], 4'b0010});
        presc_i = ps[1:0];
        for (int k = 0; k < 4; k++) begin
          int m;
          m = (k == 0) ? p - 1 : (k == 1) ? p : (k == 2) ? 3 * p + 1 : 37;
          run(m, d);
          chk(d == m / p, $sformatf("R4 cs=%0d ps=%0d m=%0d", cs, ps, m), d, m / p);
        end
      end
    end

    // R5 timer off
    wr(8'h12); presc_i = 2'd0;
    wait_n(20);
    d = 0;
    run(0, d);
    chk(d == 0, "R5 off holds", d, 0);

    // R7 / R6 gate pin, P = 2
    presc_i = 2'd1;
    gate_pin_i = 1'b0; wait_n(3);
    gate_en_i = 1'b1;
    run(20, d);
    chk(d == 0, "R7 pin low", d, 0);
    gate_en_i = 1'b0;
    run(20, d);
    chk(d == 10, "R6 gating off", d, 10);
    gate_en_i = 1'b1;
    gate_pin_i = 1'b1; wait_n(3);
    run(20, d);
    chk(d == 10, "R7 pin high", d, 10);
    gate_pin_i = 1'b0;

    // R8 comparator gate, capture off, P = 1
    presc_i = 2'd0;
    wr(8'h10);
    cmp2_i = 1'b1; wait_n(3);
    run(25, d);
    chk(d == 25, "R8 cmp high", d, 25);
    cmp2_i = 1'b0; wait_n(3);
    run(25, d);
    chk(d == 0, "R8 cmp low", d, 0);

    // R9 capture vs pass-through, P = 8
    presc_i = 2'd1;
    drop_run(1'b1, d);
    chk(d == 1, "R9 latched level used", d, 1);
    drop_run(1'b0, d);
    chk(d == 0, "R8 direct level used", d, 0);

    // R10 wrap, P = 1, gating off
    gate_en_i = 1'b0; presc_i = 2'd0;
    wr(8'h12);
    run(int'(16'hFFFF - count_o), d);
    chk(count_o == 16'hFFFF, "R10 at max", count_o, 16'hFFFF);
    tmr_on_i = 1'b1;
    @(negedge clk);
    tmr_on_i = 1'b0;
    chk(count_o == 16'h0, "R10 wrap", count_o, 0);
    chk(ovf_o == 1'b1, "R10 ovf high", ovf_o, 1);
    @(negedge clk);
    chk(ovf_o == 1'b0, "R10 ovf one cycle", ovf_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule